// File: doc/BRIEF.md
# Countdown and Free-Running Timer Bank

This block is a register-mapped timer peripheral. It holds three reloadable down-counters and one wide up-counter. Counters 0 and 1 are 16 bits wide and counter 2 is 32 bits wide. Each of these counts one step per tick from whichever of two tick-enable inputs its control register selects. When a counter steps below zero it raises a level interrupt. The counter then either reloads from its load register or wraps to all ones, depending on its mode bit. Software drops the interrupt by writing anything to that counter's clear register.

The fourth counter is 40 bits wide. It counts up on its own tick input and never interrupts. Its low 32 bits appear in one register. The upper bits and its enable bit appear in a second register.

The tick sources are generated outside the block and arrive as single-cycle enables. The bus is a simple select/write strobe with combinational read data. Writes take effect at the clock edge where the strobe is sampled.

Top module: `timer_bank`

## Requirements
- R1: After reset, every counter, load value and control field is zero, all interrupts are low, and the wide counter is disabled at zero.
- R2: Address map. Down-counter 0 sits at base 0x00, down-counter 1 at base 0x20 and down-counter 2 at base 0x80. Within each base, the load register is at +0x0, the live value at +0x4, control at +0x8 and clear at +0xC. The wide counter's low word is at 0x60 and its high word at 0x64. Clear registers and any unmapped offset read as zero.
- R3: Control register fields are run enable at bit 7, periodic mode at bit 6 and fast-tick select at bit 3. They read back at those positions, and all other control bits read as zero.
- R4: A write to a load register sets both the load value and the live count in the next cycle. It takes precedence over a tick in the same cycle.
- R5: A running down-counter decrements by one on each tick of its selected source: the fast tick when bit 3 is 1, the slow tick when bit 3 is 0. Ticks of the other source are ignored. With run enable clear, the count stays frozen.
- R6: In periodic mode, a tick at count zero reloads the load value and raises the interrupt. With load L, the interrupt recurs every L+1 ticks.
- R7: In free-run mode (bit 6 clear), a tick at count zero wraps the counter to the all-ones value of its width and still raises the interrupt.
- R8: Any write to a clear register lowers that counter's interrupt whatever the data. An underflow in the same cycle wins and leaves the interrupt high.
- R9: An interrupt rises only in the cycle after an underflow tick.
- R10: The wide counter is enabled by bit 8 of its high-word register. It counts up by one per wide tick while enabled and holds its value while disabled. Its high word reads the enable at bit 8 and counter bits 39:32 at bits 7:0. Writes to the low word are ignored.
- R11: The value register returns the live count, zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Register access select |
| wr_i | input | 1 | Write strobe (with sel_i) |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data, zero when not selected |
| tick_slow_i | input | 1 | Slow tick enable for the down-counters |
| tick_fast_i | input | 1 | Fast tick enable for the down-counters |
| tick_wide_i | input | 1 | Tick enable for the wide up-counter |
| irq_o | output | 3 | Level interrupt per down-counter |

## Verification
The bench builds the block with its default widths: 16, 16 and 32 bits for the down-counters and 40 bits for the wide counter. With the 16-bit channel, the free-run wrap to 0xFFFF is reached in two ticks. With the 32-bit channel, loading zero brings the wrap to 0xFFFFFFFF within one tick. The carry from the wide counter's low word into its high byte needs far more cycles than any run. The high word is therefore checked only for its enable bit, for holding its count, and for zero upper bits.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  localparam int REG_W       = 32;
  localparam int NUM_CH      = 3;
  localparam int CTL_EN_BIT  = 7;
  localparam int CTL_PER_BIT = 6;
  localparam int CTL_SEL_BIT = 3;
  localparam int WIDE_EN_BIT = 8;
  localparam int WIDE_LO_OFS = 'h60;
  localparam int WIDE_HI_OFS = 'h64;

  typedef enum logic [1:0] {
    RG_LOAD  = 2'd0,
    RG_VALUE = 2'd1,
    RG_CTRL  = 2'd2,
    RG_CLEAR = 2'd3
  } chan_reg_e;

  function automatic int chan_base(int idx);
    return (idx == 0) ? 'h00 : (idx == 1) ? 'h20 : 'h80;
  endfunction
endpackage

// File: rtl/tbk_chan.sv
module tbk_chan
  import timer_bank_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_slow_i,
  input  logic             tick_fast_i,
  input  logic             load_we_i,
  input  logic             ctrl_we_i,
  input  logic             clr_we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] load_o,
  output logic [REG_W-1:0] val_o,
  output logic [REG_W-1:0] ctrl_o,
  output logic             irq_o
);
  logic          en_q, per_q, sel_q, irq_q;
  logic [CW-1:0] cnt_q, load_q;
  logic          tick, under;
  logic          unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign tick  = en_q & (sel_q ? tick_fast_i : tick_slow_i);
  assign under = tick & (cnt_q == '0) & ~load_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      per_q  <= 1'b0;
      sel_q  <= 1'b0;
      load_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (ctrl_we_i) begin
        en_q  <= wdata_i[CTL_EN_BIT];
        per_q <= wdata_i[CTL_PER_BIT];
        sel_q <= wdata_i[CTL_SEL_BIT];
      end
      if (load_we_i) begin
        load_q <= wdata_i[CW-1:0];
        cnt_q  <= wdata_i[CW-1:0];
      end else if (tick) begin
        if (cnt_q == '0) cnt_q <= per_q ? load_q : '1;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // underflow beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (under)     irq_q <= 1'b1;
    else if (clr_we_i)  irq_q <= 1'b0;
  end

  assign load_o = REG_W'(load_q);
  assign val_o  = REG_W'(cnt_q);
  assign ctrl_o = (REG_W'(en_q) << CTL_EN_BIT) | (REG_W'(per_q) << CTL_PER_BIT)
                | (REG_W'(sel_q) << CTL_SEL_BIT);
  assign irq_o  = irq_q;
endmodule

// File: rtl/tbk_wide.sv
module tbk_wide
  import timer_bank_pkg::*;
#(
  parameter int WW = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hi_we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] lo_o,
  output logic [REG_W-1:0] hi_o
);
  localparam int HW = WW - REG_W;

  logic          en_q;
  logic [WW-1:0] cnt_q;
  logic          unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (hi_we_i)          en_q  <= wdata_i[WIDE_EN_BIT];
      if (en_q && tick_i)   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lo_o = cnt_q[REG_W-1:0];
  assign hi_o = REG_W'(cnt_q[WW-1:REG_W]) | (REG_W'(en_q) << WIDE_EN_BIT);

  logic [HW-1:0] unused_hw;
  assign unused_hw = '0;
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int T0_W   = 16,
  parameter int T1_W   = 16,
  parameter int T2_W   = 32,
  parameter int WIDE_W = 40,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              tick_slow_i,
  input  logic              tick_fast_i,
  input  logic              tick_wide_i,
  output logic [NUM_CH-1:0] irq_o
);
  function automatic logic [ADDR_W-1:0] reg_addr(int ch, chan_reg_e r);
    return ADDR_W'(chan_base(ch) + 4 * int'(r));
  endfunction

  localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(WIDE_LO_OFS);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(WIDE_HI_OFS);

  logic             bus_wr;
  logic [REG_W-1:0] chan_load [NUM_CH];
  logic [REG_W-1:0] chan_val  [NUM_CH];
  logic [REG_W-1:0] chan_ctrl [NUM_CH];
  logic [REG_W-1:0] wide_lo, wide_hi;

  assign bus_wr = sel_i & wr_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int CW = (g == 0) ? T0_W : (g == 1) ? T1_W : T2_W;
    tbk_chan #(.CW(CW)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_slow_i(tick_slow_i),
      .tick_fast_i(tick_fast_i),
      .load_we_i  (bus_wr && addr_i == reg_addr(g, RG_LOAD)),
      .ctrl_we_i  (bus_wr && addr_i == reg_addr(g, RG_CTRL)),
      .clr_we_i   (bus_wr && addr_i == reg_addr(g, RG_CLEAR)),
      .wdata_i    (wdata_i),
      .load_o     (chan_load[g]),
      .val_o      (chan_val[g]),
      .ctrl_o     (chan_ctrl[g]),
      .irq_o      (irq_o[g])
    );
  end

  tbk_wide #(.WW(WIDE_W)) u_wide (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_wide_i),
    .hi_we_i(bus_wr && addr_i == HI_ADDR),
    .wdata_i(wdata_i),
    .lo_o   (wide_lo),
    .hi_o   (wide_hi)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (addr_i == reg_addr(i, RG_LOAD))  rdata_o = chan_load[i];
        if (addr_i == reg_addr(i, RG_VALUE)) rdata_o = chan_val[i];
        if (addr_i == reg_addr(i, RG_CTRL))  rdata_o = chan_ctrl[i];
      end
      if (addr_i == LO_ADDR) rdata_o = wide_lo;
      if (addr_i == HI_ADDR) rdata_o = wide_hi;
    end
  end
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk #(
  parameter int T0_W   = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              tick_slow_i,
  input logic              tick_fast_i,
  input logic              tick_wide_i,
  input logic [2:0]        irq_o,
  input logic [31:0]       ch0_val_i,
  input logic [31:0]       wide_lo_i
);
  logic no_tick;
  assign no_tick = !tick_slow_i && !tick_fast_i;

  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && addr_i == ADDR_W'('h0C) && no_tick) |=> !irq_o[0]); // R8

  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o[0] && no_tick) |=> !irq_o[0]); // R9

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && wr_i && addr_i == ADDR_W'('h00)) |=> ch0_val_i == 32'($past(wdata_i[T0_W-1:0]))); // R4

  AST_WIDE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_wide_i |=> $stable(wide_lo_i)); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && addr_i == ADDR_W'('h10)) |-> rdata_o == '0); // R2
endmodule

bind timer_bank timer_bank_chk #(.T0_W(T0_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sel_i      (sel_i),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .tick_slow_i(tick_slow_i),
  .tick_fast_i(tick_fast_i),
  .tick_wide_i(tick_wide_i),
  .irq_o      (irq_o),
  .ch0_val_i  (chan_val[0]),
  .wide_lo_i  (wide_lo)
);

// File: tb/timer_bank_tb.sv
`timescale 1ns/100ps
module timer_bank_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sel_i = 1'b0, wr_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        tick_slow_i = 1'b0, tick_fast_i = 1'b0, tick_wide_i = 1'b0;
  logic [2:0]  irq_o;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0]  a;
    logic [31:0] e;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  timer_bank u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_slow_i(tick_slow_i),
    .tick_fast_i(tick_fast_i), .tick_wide_i(tick_wide_i), .irq_o(irq_o)
  );

  // monitor: compares read data half a cycle after the driver set the address
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      total++;
      if (rdata_o !== it.e) begin
        bad++;
        $display("FAIL %s addr=%02h actual=%08h expected=%08h", it.tag, it.a, rdata_o, it.e);
      end
    end
  end

  task automatic drive(bit s, bit w, logic [7:0] a, logic [31:0] d, bit ts, bit tf, bit tw);
    @(posedge clk); #1;
    sel_i = s; wr_i = w; addr_i = a; wdata_i = d;
    tick_slow_i = ts; tick_fast_i = tf; tick_wide_i = tw;
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d, bit ts = 0, bit tf = 0, bit tw = 0);
    drive(1, 1, a, d, ts, tf, tw);
  endtask

  task automatic ticks(int n, bit ts, bit tf, bit tw);
    for (int k = 0; k < n; k++) drive(0, 0, '0, '0, ts, tf, tw);
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    exp_t it;
    drive(1, 0, a, '0, 0, 0, 0);
    it.a = a; it.e = e; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic chk_irq(int b, bit e, string tag);
    drive(0, 0, '0, '0, 0, 0, 0);
    total++;
    if (irq_o[b] !== e) begin
      bad++;
      $display("FAIL %s irq[%0d] actual=%0b expected=%0b", tag, b, irq_o[b], e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset state
    rd(8'h00, 0, "R1 load0");
    rd(8'h04, 0, "R1 val0");
    rd(8'h08, 0, "R1 ctrl0");
    rd(8'h60, 0, "R1 wide lo");
    rd(8'h64, 0, "R1 wide hi");
    chk_irq(0, 0, "R1 irq0");

    // channel 0: periodic, fast tick
    bus_wr(8'h00, 32'h0000_0003);
    rd(8'h04, 3, "R4 load sets count");
    bus_wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, 32'h0000_00C8, "R3 ctrl fields");
    ticks(3, 0, 1, 0);
    rd(8'h04, 0, "R5 decrement");
    chk_irq(0, 0, "R9 no underflow yet");
    ticks(2, 1, 0, 0);
    rd(8'h04, 0, "R5 other source ignored");
    ticks(1, 0, 1, 0);
    rd(8'h04, 3, "R6 reload");
    chk_irq(0, 1, "R6 irq on underflow");
    bus_wr(8'h0C, 32'h0000_0000);
    chk_irq(0, 0, "R8 clear");
    ticks(3, 0, 1, 0);
    chk_irq(0, 0, "R6 period not done");
    ticks(1, 0, 1, 0);
    chk_irq(0, 1, "R6 period load+1");
    rd(8'h0C, 0, "R2 clear reads zero");
    bus_wr(8'h00, 32'h0000_0000);
    bus_wr(8'h0C, 32'hDEAD_BEEF);
    chk_irq(0, 0, "R8 clear any data");
    bus_wr(8'h0C, 32'h0, 0, 1, 0);
    chk_irq(0, 1, "R8 underflow beats clear");
    bus_wr(8'h08, 32'h0000_0048);
    bus_wr(8'h00, 32'h0000_0005);
    ticks(2, 0, 1, 0);
    rd(8'h04, 5, "R5 disabled frozen");

    // channel 1: free-run, slow tick
    bus_wr(8'h28, 32'h0000_0080);
    bus_wr(8'h20, 32'h0000_0001);
    rd(8'h24, 1, "R11 value ch1");
    ticks(1, 1, 0, 0);
    rd(8'h24, 0, "R5 slow tick");
    ticks(1, 1, 0, 0);
    rd(8'h24, 32'h0000_FFFF, "R7 wrap 16b");
    chk_irq(1, 1, "R7 irq on wrap");
    rd(8'h20, 1, "R7 load kept");
    rd(8'h28, 32'h0000_0080, "R3 ctrl ch1");
    ticks(2, 0, 1, 0);
    rd(8'h24, 32'h0000_FFFF, "R5 fast ignored ch1");
    bus_wr(8'h20, 32'h0000_0007, 1, 0, 0);
    rd(8'h24, 7, "R4 write beats tick");

    // channel 2: 32-bit free-run, fast tick
    bus_wr(8'h80, 32'h0000_0000);
    bus_wr(8'h88, 32'h0000_0088);
    ticks(1, 0, 1, 0);
    rd(8'h84, 32'hFFFF_FFFF, "R7 wrap 32b");
    chk_irq(2, 1, "R7 irq ch2");
    ticks(1, 0, 1, 0);
    rd(8'h84, 32'hFFFF_FFFE, "R5 ch2 decrement");
    bus_wr(8'h80, 32'h1234_5678);
    rd(8'h84, 32'h1234_5678, "R11 full width value");

    // wide counter
    ticks(2, 0, 0, 1);
    rd(8'h60, 0, "R10 disabled no count");
    bus_wr(8'h64, 32'h0000_01FF);
    rd(8'h64, 32'h0000_0100, "R10 enable readback");
    ticks(5, 0, 0, 1);
    rd(8'h60, 5, "R10 counts up");
    bus_wr(8'h60, 32'h0000_0ABC);
    rd(8'h60, 5, "R10 low write ignored");
    bus_wr(8'h64, 32'h0000_0000);
    ticks(3, 0, 0, 1);
    rd(8'h60, 5, "R10 disabled holds");

    // unmapped
    rd(8'h10, 0, "R2 unmapped 10");
    rd(8'h44, 0, "R2 unmapped 44");
    rd(8'hFC, 0, "R2 unmapped FC");

    drive(0, 0, '0, '0, 0, 0, 0);
    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule